// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a crystal time-base clock into the timing strobes that a real-time clock core and its interrupt logic consume. A prescaler first reduces the selected base to a common 32.768 kHz reference. A binary reference counter follows it, and a tap selector picks one counter stage as the periodic rate. The block drives three outputs: a one-clock periodic event strobe that sets the periodic flag, a square-wave output running at the selected rate, and a one-second update tick for the clock core.

Configuration comes from a 7-bit control field. Bits 3:0 hold the rate code and bits 6:4 hold the base code. The periodic event is produced whether or not software has enabled the interrupt, because the enable is applied where the flag is turned into a request. A two-state machine controls the divider chain. `ST_HOLD` keeps the prescaler and reference counter cleared. `ST_RUN` lets them count. Transition `T_START` (ST_HOLD to ST_RUN) is taken on the first clock on which the base code is 000, 001 or 010. Transition `T_STOP` (ST_RUN to ST_HOLD) is taken on any clock with another base code. While the base code is not valid, the chain is also gated off combinationally. All three outputs are registered.

Top module: `tick_rate_gen`

## Requirements
- R1: During reset and while base code (bits 6:4) is 110, 111 or any other value outside 000/001/010, the chain is held cleared and per_evt, sqw_out and sec_tick stay 0.
- R2: Base code 010 makes every clock a reference tick. Base code 000 makes one reference tick every 2^FAST_SHIFT clocks, and base code 001 one every 2^MID_SHIFT clocks.
- R3: Rate codes 3 to 15 (bits 3:0) give a periodic event every 2^(code-1) reference ticks on every base.
- R4: With base 010, rate code 1 gives a period of 128 reference ticks and rate code 2 a period of 256.
- R5: With base 000 or 001, rate code 1 gives a period of 1 reference tick and rate code 2 a period of 2.
- R6: Rate code 0 produces no periodic event and keeps sqw_out at 0.
- R7: per_evt is high for exactly one clock per period.
- R8: When the chain leaves hold, the first per_evt is seen one period plus one clock after the edge that latched the valid base code.
- R9: While sqw_en is 1, sqw_out is high for exactly half of every event period. While sqw_en is 0, sqw_out is 0 from the next clock.
- R10: The first sec_tick after leaving hold is seen 2^(REF_BITS) reference ticks plus one clock after the latching edge, and it lasts one clock.
- R11: Changing the rate code while running does not restart the chain. sec_tick timing is unchanged, and events take on the new period from the next tap edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal time-base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_a | input | 7 | Rate code in bits 3:0, base code in bits 6:4 |
| sqw_en | input | 1 | Square-wave output enable |
| per_evt | output | 1 | One-clock periodic event strobe |
| sqw_out | output | 1 | Square wave at the selected rate |
| sec_tick | output | 1 | One-clock strobe once per second |

## Verification
A wrong prescaler shift or tap choice shows up as an event spacing that is off by a power of two, within one period of leaving hold. A chain that is not cleared in hold shows up at once as a first-event latency that differs from period plus one clock. A square-wave bit drawn from the wrong counter stage changes the high count inside a single event period. A chain that restarts on a rate change moves the first second tick away from its exact edge, and that is visible the moment the tick arrives.

// File: rtl/trg_pkg.sv
package trg_pkg;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } chain_st_t;

    localparam logic [2:0] BASE_FAST = 3'b000;
    localparam logic [2:0] BASE_MID  = 3'b001;
    localparam logic [2:0] BASE_SLOW = 3'b010;

    function automatic logic base_ok(input logic [2:0] b);
        return (b == BASE_FAST) || (b == BASE_MID) || (b == BASE_SLOW);
    endfunction

    // Reference-tick exponent of the event period for a rate code.
    function automatic logic [3:0] tap_of(input logic [3:0] rate, input logic slow);
        logic [3:0] k;
        unique case (rate)
            4'd1:    k = slow ? 4'd7 : 4'd0;
            4'd2:    k = slow ? 4'd8 : 4'd1;
            default: k = rate - 4'd1;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/trg_prescale.sv
module trg_prescale
    import trg_pkg::*;
#(
    parameter int FAST_SHIFT = 7,
    parameter int MID_SHIFT  = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] base_sel,
    output logic       ref_tick,
    output logic       half_phase
);
    localparam int PW = FAST_SHIFT;

    logic [PW-1:0] pre_q;
    logic [PW-1:0] mask;
    logic [PW-1:0] half_bit;
    int unsigned   sh;

    always_comb begin
        unique case (base_sel)
            BASE_FAST: sh = FAST_SHIFT;
            BASE_MID:  sh = MID_SHIFT;
            default:   sh = 0;
        endcase
        mask       = PW'((32'd1 << sh) - 32'd1);
        half_bit   = mask ^ (mask >> 1);
        ref_tick   = run && ((pre_q & mask) == mask);
        half_phase = |(pre_q & half_bit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/trg_ref_chain.sv
module trg_ref_chain #(
    parameter int REF_BITS = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                ref_tick,
    output logic [REF_BITS-1:0] ref_cnt,
    output logic                sec_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt <= '0;
        end else if (!run) begin
            ref_cnt <= '0;
        end else if (ref_tick) begin
            ref_cnt <= ref_cnt + 1'b1;
        end
    end

    assign sec_o = ref_tick && (&ref_cnt);

    // R10
    sec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_o |=> !sec_o);

endmodule

// File: rtl/trg_tap_sel.sv
module trg_tap_sel
    import trg_pkg::*;
#(
    parameter int REF_BITS = 15
) (
    input  logic                run,
    input  logic [3:0]          rate,
    input  logic                slow,
    input  logic                ref_tick,
    input  logic [REF_BITS-1:0] ref_cnt,
    input  logic                half_phase,
    input  logic                sqw_en,
    output logic                evt_o,
    output logic                sqw_o
);
    logic [3:0]          k;
    logic [REF_BITS-1:0] lowmask;
    logic [REF_BITS-1:0] topbit;
    logic                active;

    always_comb begin
        k       = tap_of(rate, slow);
        lowmask = REF_BITS'((32'd1 << k) - 32'd1);
        topbit  = lowmask ^ (lowmask >> 1);
        active  = run && (rate != 4'd0);
        evt_o   = active && ref_tick && ((ref_cnt & lowmask) == lowmask);
        sqw_o   = active && sqw_en &&
                  ((k == 4'd0) ? half_phase : |(ref_cnt & topbit));
    end

endmodule

// File: rtl/tick_rate_gen.sv
module tick_rate_gen
    import trg_pkg::*;
#(
    parameter int FAST_SHIFT = 7,
    parameter int MID_SHIFT  = 5,
    parameter int REF_BITS   = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] cfg_a,
    input  logic       sqw_en,
    output logic       per_evt,
    output logic       sqw_out,
    output logic       sec_tick
);
    logic [3:0]          rate;
    logic [2:0]          base;
    chain_st_t           st_q, st_d;
    logic                chain_on;
    logic                ref_tick, half_phase;
    logic [REF_BITS-1:0] ref_cnt;
    logic                sec_c, evt_c, sqw_c;

    assign rate     = cfg_a[3:0];
    assign base     = cfg_a[6:4];
    assign chain_on = (st_q == ST_RUN) && base_ok(base);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HOLD;
        else        st_q <= st_d;
    end

    // Transitions T_START / T_STOP
    always_comb begin
        unique case (st_q)
            ST_HOLD: st_d = base_ok(base) ? ST_RUN  : ST_HOLD;
            ST_RUN:  st_d = base_ok(base) ? ST_RUN  : ST_HOLD;
        endcase
    end

    trg_prescale #(.FAST_SHIFT(FAST_SHIFT), .MID_SHIFT(MID_SHIFT)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(chain_on), .base_sel(base),
        .ref_tick(ref_tick), .half_phase(half_phase)
    );

    trg_ref_chain #(.REF_BITS(REF_BITS)) u_chain (
        .clk(clk), .rst_n(rst_n), .run(chain_on), .ref_tick(ref_tick),
        .ref_cnt(ref_cnt), .sec_o(sec_c)
    );

    trg_tap_sel #(.REF_BITS(REF_BITS)) u_tap (
        .run(chain_on), .rate(rate), .slow(base == BASE_SLOW),
        .ref_tick(ref_tick), .ref_cnt(ref_cnt), .half_phase(half_phase),
        .sqw_en(sqw_en), .evt_o(evt_c), .sqw_o(sqw_c)
    );

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_evt  <= 1'b0;
            sqw_out  <= 1'b0;
            sec_tick <= 1'b0;
        end else begin
            per_evt  <= evt_c;
            sqw_out  <= sqw_c;
            sec_tick <= sec_c;
        end
    end

    // R1
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD) |=> (!per_evt && !sqw_out && !sec_tick));

    // R6
    rate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate == 4'd0) |=> (!per_evt && !sqw_out));

    // R9
    sqw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sqw_en |=> !sqw_out);

endmodule

// File: tb/tick_rate_gen_tb.sv
`timescale 1ns/1ps
module tick_rate_gen_tb;
    localparam int FS = 3;
    localparam int MS = 2;
    localparam int RB = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cfg = 7'b111_0000;
    logic       sqw_en = 1'b0;
    logic       per_evt, sqw_out, sec_tick;
    int         checks = 0;
    int         errs = 0;

    always #2.5 clk = ~clk;

    tick_rate_gen #(.FAST_SHIFT(FS), .MID_SHIFT(MS), .REF_BITS(RB)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_a(cfg), .sqw_en(sqw_en),
        .per_evt(per_evt), .sqw_out(sqw_out), .sec_tick(sec_tick)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int kof(input int rate, input bit slow);
        if (rate >= 3) return rate - 1;
        if (rate == 1) return slow ? 7 : 0;
        return slow ? 8 : 1;
    endfunction

    function automatic int sof(input int base);
        if (base == 0) return FS;
        if (base == 1) return MS;
        return 0;
    endfunction

    task automatic go_hold(input logic [3:0] rate);
        @(negedge clk);
        cfg = {3'b111, rate};
        repeat (3) @(negedge clk);
    endtask

    task automatic measure(input logic [2:0] base, input logic [3:0] rate, input bit en);
        int k, s, n, cnt, hi;
        bit w;
        string tag;
        k = kof(int'(rate), base == 3'd2);
        s = sof(int'(base));
        n = 1 << (k + s);
        tag = (rate >= 4'd3) ? "R3 R2" : ((base == 3'd2) ? "R4" : "R5 R2");
        go_hold(rate);
        sqw_en = en;
        cfg = {base, rate};
        cnt = 0;
        do begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
        end while (!per_evt && cnt < 2 * n + 8);
        chk(cnt == n + 1, "R8 first event latency", cnt, n + 1);
        cnt = 0; hi = 0; w = 1'b0;
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) w = per_evt;
            if (sqw_out) hi++;
        end while (!per_evt && cnt < 2 * n + 8);
        chk(w == 1'b0, "R7 event width", int'(w), 0);
        chk(cnt == n, tag, cnt, n);
        chk(hi == (en ? n / 2 : 0), "R9 square wave high count", hi, en ? n / 2 : 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int cnt, hits, nev, last, iv;
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(!per_evt && !sqw_out && !sec_tick, "R1 reset outputs",
            int'({per_evt, sqw_out, sec_tick}), 0);
        rst_n = 1'b1;
        // R1: hold codes 110, 111, 101 with a live rate and square wave enabled
        sqw_en = 1'b1;
        foreach (cfg[i]) begin end
        for (int b = 5; b <= 7; b++) begin
            @(negedge clk);
            cfg = {3'(b), 4'd3};
            hits = 0;
            for (int c = 0; c < 300; c++) begin
                @(negedge clk);
                if (per_evt || sqw_out || sec_tick) hits++;
            end
            chk(hits == 0, "R1 hold base code quiet", hits, 0);
        end
        // R6: rate 0 while running
        for (int b = 0; b <= 2; b++) begin
            go_hold(4'd0);
            cfg = {3'(b), 4'd0};
            hits = 0;
            for (int c = 0; c < 400; c++) begin
                @(negedge clk);
                if (per_evt || sqw_out) hits++;
            end
            chk(hits == 0, "R6 rate zero quiet", hits, 0);
        end
        // Sweeps
        for (int r = 1; r <= 15; r++) measure(3'd2, 4'(r), r[0]);
        for (int r = 1; r <= 8; r++)  measure(3'd0, 4'(r), !r[0]);
        for (int r = 1; r <= 8; r++)  measure(3'd1, 4'(r), r[0]);
        // R9: disabling square wave mid-run
        @(negedge clk);
        sqw_en = 1'b0;
        hits = 0;
        for (int c = 0; c < 64; c++) begin
            @(negedge clk);
            if (sqw_out) hits++;
        end
        chk(hits == 0, "R9 square wave disabled", hits, 0);
        // R10 / R11: second tick timing with a rate change part way
        go_hold(4'd3);
        cfg = {3'd2, 4'd3};
        cnt = 0; nev = 0; last = 0; iv = 0;
        do begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (cnt == 1000) cfg = {3'd2, 4'd6};
            if (cnt > 1000 && per_evt) begin
                nev++;
                if (nev == 3) iv = cnt - last;
                last = cnt;
            end
        end while (!sec_tick && cnt < 40000);
        chk(cnt == (1 << RB) + 1, "R10 R11 first second tick", cnt, (1 << RB) + 1);
        chk(iv == 32, "R11 new period after change", iv, 32);
        @(negedge clk);
        chk(!sec_tick, "R10 second tick width", int'(sec_tick), 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule